// File: doc/BRIEF.md
# Three-Wire Serial Word Memory Slave

This block is the slave side of a three-wire serial memory with a select line, a serial clock and one data line in each direction. Its storage is an on-chip array of 16-bit words. A host raises chip select and clocks in an instruction one bit per serial clock edge. The block then reads out words, programs them, or changes its write protection. All of it runs in one system clock domain. The serial pins pass through a short synchronizer, and the block acts only on detected rising edges of the serial clock.

A read does not stop after one word. The block keeps shifting out the next word for as long as chip select stays high. After the top address it continues at address zero. One zero bit comes before the first word only. Programming commands are refused until write enable has been issued. A programming command that is accepted starts a busy interval. After the host lowers and raises chip select, the data line reports that interval as a status bit.

Top module: `mw_serial_eeprom`

## Requirements
- R1: An instruction is a 1 start bit, then a 2-bit opcode, then an ADDR_W-bit address, then DATA_W data bits for the commands that carry data. Every field is sent MSB first, and sdi is sampled on rising edges of sclk.
- R2: Opcode 10 reads, 01 writes and 11 erases one word. Opcode 00 looks at the two top address bits: 11 enables writes, 00 disables writes, 10 writes all words and 01 erases all words.
- R3: After the last address bit of a read is clocked in, sdo drives a single 0. Each later sclk rising edge then presents the next data bit, MSB first.
- R4: Write, erase, write-all and erase-all change no word unless write enable is set. Reset clears write enable, and the disable command also clears it.
- R5: An enabled write stores its data word at the given address. An enabled erase sets that word to all ones.
- R6: While cs stays high, the LSB of a word is followed directly by the MSB of the word at the next address, with no extra zero bit. The address wraps from the top location to 0.
- R7: Zero bits before the start bit are skipped. When sclk stops high or low for any length of time, the decoder and the output keep their state.
- R8: After an accepted programming command, once cs has been lowered and raised again, sdo reads 0 while busy and 1 when ready. The busy interval is BUSY_CYC clock cycles. New instructions are not accepted while busy.
- R9: cs low aborts any partial instruction and forces sdo to 1.
- R10: An enabled write-all stores its data in every word. An enabled erase-all sets every word to all ones.
- R11: After reset every word reads all ones when INIT_ONES is 1, which is the default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select, active high |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data into the block |
| sdo | output | 1 | Serial data out of the block |

## Verification
A wrong bit count in the decoder shows up at the first read. The dummy zero lands in the wrong sclk period, or every following data bit comes out shifted by one position. A write-enable flag left in the wrong state shows up as soon as a protected word is read back. The same fault shows at the status bit, which reads busy or ready when it should read the other, on the very next chip select cycle. A read address that fails to advance or wrap shows within 17 sclk periods after the first word, when the second word repeats or comes from the wrong location.

// File: rtl/mw_pkg.sv
package mw_pkg;
   typedef enum logic [1:0] {
      OP_EXT   = 2'b00,
      OP_WRITE = 2'b01,
      OP_READ  = 2'b10,
      OP_ERASE = 2'b11
   } mw_op_e;

   typedef enum logic [1:0] {
      EXT_LOCK  = 2'b00,
      EXT_CLRALL = 2'b01,
      EXT_FILL  = 2'b10,
      EXT_UNLOCK = 2'b11
   } mw_ext_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_OPC,
      ST_ADDR,
      ST_DATA,
      ST_READ,
      ST_DONE
   } mw_state_e;
endpackage

// File: rtl/mw_in_sync.sv
module mw_in_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_i,
   input  logic sclk_i,
   input  logic sdi_i,
   output logic cs_o,
   output logic sdi_o,
   output logic rise_o
);
   logic [2:0] pipe [STAGES];
   logic       sclk_prev;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[g] <= '0;
            else        pipe[g] <= {cs_i, sclk_i, sdi_i};
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[g] <= '0;
            else        pipe[g] <= pipe[g-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_prev <= 1'b0;
      else        sclk_prev <= pipe[STAGES-1][1];
   end

   assign cs_o   = pipe[STAGES-1][2];
   assign sdi_o  = pipe[STAGES-1][0];
   assign rise_o = pipe[STAGES-1][1] & ~sclk_prev;
endmodule

// File: rtl/mw_busy_timer.sv
module mw_busy_timer #(
   parameter int BUSY_CYC = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   localparam int TW = $clog2(BUSY_CYC + 1);
   logic [TW-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              remain <= '0;
      else if (start)          remain <= TW'(BUSY_CYC);
      else if (remain != '0)   remain <= remain - 1'b1;
   end

   assign busy = (remain != '0);
endmodule

// File: rtl/mw_word_store.sv
module mw_word_store #(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 16,
   parameter bit INIT_ONES = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic              we_all,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;
   logic [DATA_W-1:0] mem [DEPTH];

   if (INIT_ONES) begin : g_reset_ones
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
         end else if (we_all) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= wdata;
         end else if (we) begin
            mem[waddr] <= wdata;
         end
      end
   end else begin : g_no_reset
      always_ff @(posedge clk) begin
         if (we_all) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= wdata;
         end else if (we) begin
            mem[waddr] <= wdata;
         end
      end
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/mw_serial_ctrl.sv
module mw_serial_ctrl
   import mw_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs,
   input  logic              sdi,
   input  logic              rise,
   input  logic              busy,
   input  logic [DATA_W-1:0] rdata,
   output logic [ADDR_W-1:0] raddr,
   output logic              we,
   output logic              we_all,
   output logic [ADDR_W-1:0] waddr,
   output logic [DATA_W-1:0] wdata,
   output logic              wen,
   output mw_state_e         st,
   output logic              sdo
);
   localparam int MAXW = (DATA_W > ADDR_W) ? DATA_W : ADDR_W;
   localparam int CW   = $clog2(MAXW) + 1;

   mw_state_e         state_q;
   logic [CW-1:0]     cnt_q;
   logic [1:0]        op_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic [DATA_W-1:0] sh_q;
   logic              sdo_q;
   logic              wen_q;
   logic              fill_q;
   logic              we_q, we_all_q;
   logic [ADDR_W-1:0] waddr_q;
   logic [DATA_W-1:0] wdata_q;

   logic [ADDR_W-1:0] addr_next;
   logic [DATA_W-1:0] data_next;
   logic [1:0]        ext_sel;

   assign addr_next = {addr_q[ADDR_W-2:0], sdi};
   assign data_next = {data_q[DATA_W-2:0], sdi};
   assign ext_sel   = addr_next[ADDR_W-1 -: 2];
   assign raddr     = (state_q == ST_READ) ? addr_q + 1'b1 : addr_next;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         cnt_q    <= '0;
         op_q     <= '0;
         addr_q   <= '0;
         data_q   <= '0;
         sh_q     <= '0;
         sdo_q    <= 1'b1;
         wen_q    <= 1'b0;
         fill_q   <= 1'b0;
         we_q     <= 1'b0;
         we_all_q <= 1'b0;
         waddr_q  <= '0;
         wdata_q  <= '0;
      end else begin
         we_q     <= 1'b0;
         we_all_q <= 1'b0;
         if (!cs) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
         end else if (rise) begin
            unique case (state_q)
               ST_IDLE: begin
                  if (sdi && !busy) begin
                     state_q <= ST_OPC;
                     cnt_q   <= '0;
                  end
               end
               ST_OPC: begin
                  op_q <= {op_q[0], sdi};
                  if (cnt_q == CW'(1)) begin
                     state_q <= ST_ADDR;
                     cnt_q   <= '0;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               ST_ADDR: begin
                  addr_q <= addr_next;
                  if (cnt_q == CW'(ADDR_W - 1)) begin
                     cnt_q   <= '0;
                     state_q <= ST_DONE;
                     unique case (mw_op_e'(op_q))
                        OP_READ: begin
                           sh_q    <= rdata;
                           sdo_q   <= 1'b0;
                           state_q <= ST_READ;
                        end
                        OP_WRITE: begin
                           fill_q  <= 1'b0;
                           state_q <= ST_DATA;
                        end
                        OP_ERASE: begin
                           we_q    <= wen_q;
                           waddr_q <= addr_next;
                           wdata_q <= '1;
                        end
                        OP_EXT: begin
                           unique case (mw_ext_e'(ext_sel))
                              EXT_UNLOCK: wen_q <= 1'b1;
                              EXT_LOCK:   wen_q <= 1'b0;
                              EXT_FILL: begin
                                 fill_q  <= 1'b1;
                                 state_q <= ST_DATA;
                              end
                              EXT_CLRALL: begin
                                 we_all_q <= wen_q;
                                 wdata_q  <= '1;
                              end
                           endcase
                        end
                     endcase
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               ST_DATA: begin
                  data_q <= data_next;
                  if (cnt_q == CW'(DATA_W - 1)) begin
                     cnt_q    <= '0;
                     state_q  <= ST_DONE;
                     we_q     <= wen_q & ~fill_q;
                     we_all_q <= wen_q & fill_q;
                     waddr_q  <= addr_q;
                     wdata_q  <= data_next;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               ST_READ: begin
                  sdo_q <= sh_q[DATA_W-1];
                  if (cnt_q == CW'(DATA_W - 1)) begin
                     cnt_q  <= '0;
                     sh_q   <= rdata;
                     addr_q <= addr_q + 1'b1;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                     sh_q  <= {sh_q[DATA_W-2:0], 1'b0};
                  end
               end
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      if (!cs)                     sdo = 1'b1;
      else if (state_q == ST_READ) sdo = sdo_q;
      else if (state_q == ST_IDLE) sdo = ~busy;
      else                         sdo = 1'b1;
   end

   assign we     = we_q;
   assign we_all = we_all_q;
   assign waddr  = waddr_q;
   assign wdata  = wdata_q;
   assign wen    = wen_q;
   assign st     = state_q;
endmodule

// File: rtl/mw_serial_eeprom.sv
module mw_serial_eeprom
   import mw_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 16,
   parameter int BUSY_CYC    = 64,
   parameter int SYNC_STAGES = 2,
   parameter bit INIT_ONES   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs,
   input  logic sclk,
   input  logic sdi,
   output logic sdo
);
   if (ADDR_W < 2 || ADDR_W > 12) begin : g_bad_addr
      $error("mw_serial_eeprom: ADDR_W must be within 2..12");
   end
   if (DATA_W < 2) begin : g_bad_data
      $error("mw_serial_eeprom: DATA_W must be at least 2");
   end
   if (BUSY_CYC < 1) begin : g_bad_busy
      $error("mw_serial_eeprom: BUSY_CYC must be at least 1");
   end
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("mw_serial_eeprom: SYNC_STAGES must be at least 1");
   end

   logic              cs_s, sdi_s, rise;
   logic              busy, we, we_all, wen;
   logic [ADDR_W-1:0] raddr, waddr;
   logic [DATA_W-1:0] rdata, wdata;
   mw_state_e         st;

   mw_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .cs_i(cs), .sclk_i(sclk), .sdi_i(sdi),
      .cs_o(cs_s), .sdi_o(sdi_s), .rise_o(rise)
   );

   mw_serial_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .cs(cs_s), .sdi(sdi_s), .rise(rise),
      .busy(busy), .rdata(rdata), .raddr(raddr), .we(we), .we_all(we_all),
      .waddr(waddr), .wdata(wdata), .wen(wen), .st(st), .sdo(sdo)
   );

   mw_word_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .INIT_ONES(INIT_ONES)) u_store (
      .clk(clk), .rst_n(rst_n), .we(we), .we_all(we_all), .waddr(waddr),
      .wdata(wdata), .raddr(raddr), .rdata(rdata)
   );

   mw_busy_timer #(.BUSY_CYC(BUSY_CYC)) u_busy (
      .clk(clk), .rst_n(rst_n), .start(we | we_all), .busy(busy)
   );
endmodule

// File: rtl/mw_serial_eeprom_chk.sv
module mw_serial_eeprom_chk
   import mw_pkg::*;
(
   input logic      clk,
   input logic      rst_n,
   input logic      cs_s,
   input logic      rise,
   input logic      busy,
   input logic      we,
   input logic      we_all,
   input logic      wen,
   input mw_state_e st,
   input logic      sdo
);
   logic in_read;
   assign in_read = (st == ST_READ);

   assert_sdo_high_deselect_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_s |-> sdo);

   assert_no_prog_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (we || we_all) |-> wen);

   assert_busy_after_prog_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (we || we_all) |=> busy);

   assert_dummy_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_read) |-> !sdo);

   assert_hold_without_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_s && !rise) |=> $stable(st));

   assert_single_prog_kind_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && we_all));
endmodule

bind mw_serial_eeprom mw_serial_eeprom_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .rise(rise), .busy(busy),
   .we(we), .we_all(we_all), .wen(wen), .st(st), .sdo(sdo)
);

// File: tb/tb_mw_serial_eeprom.sv
module tb_mw_serial_eeprom;
   localparam int HALF = 6;
   localparam int BUSY = 64;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs = 1'b0, sclk = 1'b0, sdi = 1'b0;
   logic sdo;
   int   n_chk = 0, n_fail = 0;
   logic [15:0] rd_buf [4];

   always #5 clk = ~clk;

   mw_serial_eeprom #(.BUSY_CYC(BUSY)) dut (
      .clk(clk), .rst_n(rst_n), .cs(cs), .sclk(sclk), .sdi(sdi), .sdo(sdo)
   );

   task automatic wclk(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic bit_out(input logic b, input int hold);
      sclk = 1'b0; sdi = b; wclk(hold);
      sclk = 1'b1; wclk(hold);
   endtask

   task automatic send(input logic [31:0] v, input int n);
      for (int i = n - 1; i >= 0; i--) bit_out(v[i], HALF);
   endtask

   task automatic sel_on();
      sclk = 1'b0; cs = 1'b1; wclk(HALF);
   endtask

   task automatic sel_off();
      sclk = 1'b0; cs = 1'b0; sdi = 1'b0; wclk(HALF);
   endtask

   task automatic header(input logic [1:0] op, input logic [7:0] a);
      send(1, 1); send({30'd0, op}, 2); send({24'd0, a}, 8);
   endtask

   // after a command: lower/raise cs and check busy then ready (R8)
   task automatic status(input bit expect_busy, input string tag);
      int waited;
      sel_off();
      cs = 1'b1; wclk(4);
      chk({tag, " R8 status right after"}, {31'd0, sdo}, {31'd0, !expect_busy});
      waited = 0;
      while (sdo !== 1'b1 && waited < BUSY + 20) begin wclk(1); waited++; end
      chk({tag, " R8 ready reached"}, {31'd0, sdo}, 32'd1);
      sel_off();
   endtask

   task automatic prog(input logic [1:0] op, input logic [7:0] a, input bit has_data,
                       input logic [15:0] d, input bit expect_busy, input string tag);
      sel_on();
      header(op, a);
      if (has_data) send({16'd0, d}, 16);
      status(expect_busy, tag);
   endtask

   task automatic read_n(input logic [7:0] a, input int n, input int hold, input string tag);
      sel_on();
      header(2'b10, a);
      chk({tag, " R3 dummy zero"}, {31'd0, sdo}, 32'd0);
      for (int w = 0; w < n; w++) begin
         for (int b = 15; b >= 0; b--) begin
            sclk = 1'b0; wclk(hold);
            sclk = 1'b1; wclk(hold);
            rd_buf[w][b] = sdo;
         end
      end
      sel_off();
   endtask

   task automatic t_reset();
      chk("R9 sdo high after reset", {31'd0, sdo}, 32'd1);
      read_n(8'h05, 1, HALF, "reset");
      chk("R11 word 05 all ones", {16'd0, rd_buf[0]}, 32'h0000_FFFF);
   endtask

   task automatic t_locked_write();
      prog(2'b01, 8'h05, 1, 16'h1234, 0, "locked write R4");
      read_n(8'h05, 1, HALF, "locked");
      chk("R4 locked write ignored", {16'd0, rd_buf[0]}, 32'h0000_FFFF);
   endtask

   task automatic t_write_read();
      prog(2'b00, 8'hC0, 0, 16'h0, 0, "unlock R2");
      prog(2'b01, 8'h05, 1, 16'hA5C3, 1, "write 05 R5");
      prog(2'b01, 8'h06, 1, 16'h0F0F, 1, "write 06 R5");
      read_n(8'h05, 2, HALF, "pair");
      chk("R5 R1 word 05", {16'd0, rd_buf[0]}, 32'h0000_A5C3);
      chk("R6 next word 06", {16'd0, rd_buf[1]}, 32'h0000_0F0F);
   endtask

   task automatic t_wrap();
      prog(2'b01, 8'hFF, 1, 16'h1357, 1, "write FF");
      read_n(8'hFF, 2, HALF, "wrap");
      chk("R6 top word", {16'd0, rd_buf[0]}, 32'h0000_1357);
      chk("R6 wrapped to 00", {16'd0, rd_buf[1]}, 32'h0000_FFFF);
   endtask

   task automatic t_erase();
      prog(2'b11, 8'h05, 0, 16'h0, 1, "erase 05");
      read_n(8'h05, 2, HALF, "erase");
      chk("R5 erased word", {16'd0, rd_buf[0]}, 32'h0000_FFFF);
      chk("R5 neighbour kept", {16'd0, rd_buf[1]}, 32'h0000_0F0F);
   endtask

   task automatic t_abort();
      sel_on();
      send(1, 1); send(32'b01, 2); send(32'b0000, 4);
      sel_off();
      sel_on(); wclk(2);
      chk("R9 abort left block ready", {31'd0, sdo}, 32'd1);
      sel_off();
      read_n(8'h07, 1, HALF, "abort");
      chk("R9 aborted write stored nothing", {16'd0, rd_buf[0]}, 32'h0000_FFFF);
   endtask

   task automatic t_zeros_stall();
      sel_on();
      send(0, 3);
      header(2'b10, 8'h06);
      chk("R7 R3 dummy after leading zeros", {31'd0, sdo}, 32'd0);
      for (int b = 15; b >= 0; b--) begin
         sclk = 1'b0; wclk(40);
         sclk = 1'b1; wclk(40);
         rd_buf[0][b] = sdo;
      end
      sel_off();
      chk("R7 stalled clock read", {16'd0, rd_buf[0]}, 32'h0000_0F0F);
   endtask

   task automatic t_all();
      prog(2'b00, 8'h80, 1, 16'h2468, 1, "fill R10");
      read_n(8'h00, 1, HALF, "fill0");
      chk("R10 fill word 00", {16'd0, rd_buf[0]}, 32'h0000_2468);
      read_n(8'hC8, 1, HALF, "fillC8");
      chk("R10 fill word C8", {16'd0, rd_buf[0]}, 32'h0000_2468);
      prog(2'b00, 8'h40, 0, 16'h0, 1, "clear R10");
      read_n(8'h06, 1, HALF, "clear");
      chk("R10 erase-all word 06", {16'd0, rd_buf[0]}, 32'h0000_FFFF);
   endtask

   task automatic t_lock();
      prog(2'b00, 8'h00, 0, 16'h0, 0, "lock R2");
      prog(2'b01, 8'h03, 1, 16'hBEEF, 0, "write after lock R4");
      read_n(8'h03, 1, HALF, "lock");
      chk("R4 write after disable ignored", {16'd0, rd_buf[0]}, 32'h0000_FFFF);
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      wclk(3);
      rst_n = 1'b1;
      wclk(3);
      t_reset();
      t_locked_write();
      t_write_read();
      t_wrap();
      t_erase();
      t_abort();
      t_zeros_stall();
      t_all();
      t_lock();
      summary();
   end
endmodule